// File: doc/BRIEF.md
# Deferred Machine-Check Error Recorder

This block sits beside the retirement logic of a pipelined core. It collects uncorrectable memory errors and decides when a machine-check trap request goes to the trap logic, and whether that request is precise or imprecise. An error seen by an in-flight load does not flush the pipeline. It is kept as a pending status bit in a table indexed by the load's instruction ID. If that load later retires, the bit turns into a precise request. If the load is squashed instead, the bit is discarded. A configuration bit can change this: when it is set and the squash comes from an older branch mispredict, the bit becomes an imprecise request at that moment.

A store whose data was already handed to the write buffer has no live instruction to carry its error, so an error strobe from the store buffer always produces an imprecise request. Two saturating counters record how many precise and how many imprecise errors have been reported. A single strobe clears both counters. The request output is a one-cycle pulse that goes out one cycle after the causing event. When requests compete, imprecise requests go first and a precise request waits its turn.

Top module: `mce_recorder`

## Requirements
- R1: An error report (`err_vld`, `err_id`) marks that ID as pending. When a pending ID retires, `mc_req`=1 with `mc_precise`=1 in the cycle after the retirement.
- R2: Retiring an ID that has no pending error produces no request and leaves the precise counter unchanged.
- R3: A store-buffer error strobe (`st_err`=1) gives `mc_req`=1 with `mc_precise`=0 in the next cycle.
- R4: A squash with `sq_mispred`=1 and `cfg_wp_raise`=0 discards the pending error of that ID. No request follows, and a later retirement of that ID raises nothing.
- R5: A squash with `sq_mispred`=1 and `cfg_wp_raise`=1 on a pending ID gives an imprecise request (`mc_req`=1, `mc_precise`=0) in the next cycle.
- R6: A squash with `sq_mispred`=0 discards the pending error of that ID without a request, whatever the value of `cfg_wp_raise`.
- R7: An error report and a retirement of the same ID in the same cycle count as a pending error retiring, so a precise request follows.
- R8: When an imprecise event and a precise event fall in the same cycle, the next cycle carries the imprecise request and the cycle after carries the precise one. Both are counted.
- R9: `cnt_precise` increments once per precise request event. `cnt_imprecise` increments once per imprecise event, by up to 2 in one cycle (store error plus wrong-path raise).
- R10: Both counters saturate at 2^CNT_W-1 and never wrap.
- R11: `cnt_clr`=1 sets both counters to 0 in the next cycle. It wins over an increment in the same cycle.
- R12: After reset, `mc_req`=0, `mc_precise`=0, both counters are 0, and no ID is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wp_raise | input | 1 | Turn mispredict-squashed pending errors into imprecise requests |
| err_vld | input | 1 | Uncorrectable load error report |
| err_id | input | ID_W | Instruction ID of the erroring load |
| ret_vld | input | 1 | Retirement notification |
| ret_id | input | ID_W | ID being retired |
| sq_vld | input | 1 | Squash notification |
| sq_id | input | ID_W | ID being squashed |
| sq_mispred | input | 1 | Squash caused by an older branch mispredict |
| st_err | input | 1 | Error on a store already in the write buffer |
| cnt_clr | input | 1 | Clear both counters |
| mc_req | output | 1 | Machine-check request pulse |
| mc_precise | output | 1 | Request is precise (valid with mc_req) |
| cnt_precise | output | CNT_W | Precise error count |
| cnt_imprecise | output | CNT_W | Imprecise error count |

## Verification
A store-buffer error can arrive in the same cycle as a pending load retires, and the two requests then compete for the single request output. The bench triggers this by driving `st_err` in the same cycle as the retirement of an ID marked earlier. It then expects an imprecise pulse in the next cycle, a precise pulse in the cycle after, and an increment of each counter. A clear strobe that coincides with a store error is checked the same way, and the bench expects a zero count.

// File: rtl/mce_pkg.sv
`timescale 1ns/1ps
package mce_pkg;
  typedef enum logic [1:0] {
    MC_NONE = 2'd0,
    MC_IMP  = 2'd1,
    MC_PREC = 2'd2
  } mc_kind_e;
endpackage

// File: rtl/mce_pend_tbl.sv
`timescale 1ns/1ps
module mce_pend_tbl #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_vld,
  input  logic [ID_W-1:0] err_id,
  input  logic            ret_vld,
  input  logic [ID_W-1:0] ret_id,
  input  logic            sq_vld,
  input  logic [ID_W-1:0] sq_id,
  output logic            ret_hit,
  output logic            sq_hit
);
  localparam int DEPTH = 1 << ID_W;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic             tbl_en;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic set_e, clr_e;
    always_comb begin
      set_e = err_vld && (err_id == ID_W'(gi));
      clr_e = (ret_vld && (ret_id == ID_W'(gi))) || (sq_vld && (sq_id == ID_W'(gi)));
      valid_d[gi] = clr_e ? 1'b0 : (valid_q[gi] | set_e);
    end
  end

  always_comb begin
    tbl_en  = err_vld | ret_vld | sq_vld;
    ret_hit = ret_vld && (valid_q[ret_id] || (err_vld && (err_id == ret_id)));
    sq_hit  = sq_vld  && (valid_q[sq_id]  || (err_vld && (err_id == sq_id)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (tbl_en) valid_q <= valid_d;
  end

  AST_ERR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && !(ret_vld && ret_id == err_id) && !(sq_vld && sq_id == err_id))
    |=> valid_q[$past(err_id)]); // R1
  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |=> !valid_q[$past(sq_id)]); // R4
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld |=> !valid_q[$past(ret_id)]); // R2
endmodule

// File: rtl/mce_sat_cnt.sv
`timescale 1ns/1ps
module mce_sat_cnt #(
  parameter int W     = 8,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         cnt_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + {{(W+1-INC_W){1'b0}}, inc};
    cnt_en = clr | (inc != '0);
    if (clr)             cnt_d = '0;
    else if (sum > MAXV) cnt_d = MAXV[W-1:0];
    else                 cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q)); // R10
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R11
endmodule

// File: rtl/mce_req_arb.sv
`timescale 1ns/1ps
module mce_req_arb
  import mce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prec_evt,
  input  logic imp_evt,
  output logic mc_req,
  output logic mc_precise
);
  mc_kind_e kind_q, kind_d;
  logic     hold_q, hold_d;
  logic     prec_any;

  always_comb begin
    prec_any = prec_evt | hold_q;
    if (imp_evt) begin
      kind_d = MC_IMP;
      hold_d = prec_any;
    end else if (prec_any) begin
      kind_d = MC_PREC;
      hold_d = 1'b0;
    end else begin
      kind_d = MC_NONE;
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= MC_NONE;
      hold_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      hold_q <= hold_d;
    end
  end

  assign mc_req     = (kind_q != MC_NONE);
  assign mc_precise = (kind_q == MC_PREC);

  AST_IMP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (imp_evt && prec_evt) |=> (mc_req && !mc_precise && hold_q)); // R8
  AST_HELD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !imp_evt) |=> (mc_req && mc_precise)); // R8
endmodule

// File: rtl/mce_recorder.sv
`timescale 1ns/1ps
module mce_recorder #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wp_raise,
  input  logic             err_vld,
  input  logic [ID_W-1:0]  err_id,
  input  logic             ret_vld,
  input  logic [ID_W-1:0]  ret_id,
  input  logic             sq_vld,
  input  logic [ID_W-1:0]  sq_id,
  input  logic             sq_mispred,
  input  logic             st_err,
  input  logic             cnt_clr,
  output logic             mc_req,
  output logic             mc_precise,
  output logic [CNT_W-1:0] cnt_precise,
  output logic [CNT_W-1:0] cnt_imprecise
);
  logic       ret_hit, sq_hit;
  logic       prec_evt, wp_raise, imp_evt;
  logic [1:0] imp_inc;

  mce_pend_tbl #(.ID_W(ID_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .err_vld(err_vld), .err_id(err_id),
    .ret_vld(ret_vld), .ret_id(ret_id),
    .sq_vld(sq_vld), .sq_id(sq_id),
    .ret_hit(ret_hit), .sq_hit(sq_hit)
  );

  always_comb begin
    prec_evt = ret_hit;
    wp_raise = sq_hit && sq_mispred && cfg_wp_raise;
    imp_evt  = st_err | wp_raise;
    imp_inc  = {1'b0, st_err} + {1'b0, wp_raise};
  end

  mce_req_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .prec_evt(prec_evt), .imp_evt(imp_evt),
    .mc_req(mc_req), .mc_precise(mc_precise)
  );

  mce_sat_cnt #(.W(CNT_W), .INC_W(1)) u_cnt_prec (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .inc(prec_evt), .cnt(cnt_precise)
  );

  mce_sat_cnt #(.W(CNT_W), .INC_W(2)) u_cnt_imp (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .inc(imp_inc), .cnt(cnt_imprecise)
  );

  AST_STORE_IMPRECISE: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |=> (mc_req && !mc_precise)); // R3
  AST_PRECISE_FLAG_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    mc_precise |-> mc_req); // R1
  AST_PLAIN_SQUASH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && !sq_mispred && !st_err && !ret_hit && !mc_req)
    |=> !mc_req); // R6
endmodule

// File: tb/test_mce_recorder.sv
`timescale 1ns/1ps
module test_mce_recorder;
  localparam int ID_W  = 4;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic            e;
    logic [ID_W-1:0] eid;
    logic            r;
    logic [ID_W-1:0] rid;
    logic            s;
    logic [ID_W-1:0] sid;
    logic            m;
    logic            st;
    logic            cfg;
    logic            xr;
    logic            xp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // idle
    '{1'b1,4'd3,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 mark 3
    '{1'b0,4'd0,1'b1,4'd3,1'b0,4'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R1 retire 3
    '{1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,4'd5,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R4 mark 5
    '{1'b0,4'd0,1'b0,4'd0,1'b1,4'd5,1'b1,1'b0,1'b0,1'b0,1'b0}, // R4 drop
    '{1'b0,4'd0,1'b1,4'd5,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R4/R2 retire
    '{1'b1,4'd6,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R5 mark 6
    '{1'b0,4'd0,1'b0,4'd0,1'b1,4'd6,1'b1,1'b0,1'b1,1'b1,1'b0}, // R5 raise
    '{1'b1,4'd7,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R6 mark 7
    '{1'b0,4'd0,1'b0,4'd0,1'b1,4'd7,1'b0,1'b0,1'b1,1'b0,1'b0}, // R6 plain squash
    '{1'b1,4'd8,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R8 mark 8
    '{1'b0,4'd0,1'b1,4'd8,1'b0,4'd0,1'b0,1'b1,1'b0,1'b1,1'b0}, // R8 imp first
    '{1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R8 prec next
    '{1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,4'd0,1'b1,4'd9,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 clean retire
    '{1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b1,1'b0,1'b1,1'b0}, // R3 store
    '{1'b1,4'd2,1'b1,4'd2,1'b0,4'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R7 same cycle
    '{1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wp_raise, err_vld, ret_vld, sq_vld, sq_mispred, st_err, cnt_clr;
  logic [ID_W-1:0] err_id, ret_id, sq_id;
  logic mc_req, mc_precise;
  logic [CNT_W-1:0] cnt_precise, cnt_imprecise;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mce_recorder #(.ID_W(ID_W), .CNT_W(CNT_W)) i_mce_recorder (
    .clk(clk), .rst_n(rst_n), .cfg_wp_raise(cfg_wp_raise),
    .err_vld(err_vld), .err_id(err_id),
    .ret_vld(ret_vld), .ret_id(ret_id),
    .sq_vld(sq_vld), .sq_id(sq_id), .sq_mispred(sq_mispred),
    .st_err(st_err), .cnt_clr(cnt_clr),
    .mc_req(mc_req), .mc_precise(mc_precise),
    .cnt_precise(cnt_precise), .cnt_imprecise(cnt_imprecise)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    cfg_wp_raise = 1'b0; err_vld = 1'b0; err_id = '0;
    ret_vld = 1'b0; ret_id = '0; sq_vld = 1'b0; sq_id = '0;
    sq_mispred = 1'b0; st_err = 1'b0; cnt_clr = 1'b0;
  endtask

  initial begin
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 mc_req", int'(mc_req), 0);
    chk("R12 cnt_precise", int'(cnt_precise), 0);
    chk("R12 cnt_imprecise", int'(cnt_imprecise), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cfg_wp_raise = VECS[i].cfg;
      err_vld = VECS[i].e;  err_id = VECS[i].eid;
      ret_vld = VECS[i].r;  ret_id = VECS[i].rid;
      sq_vld  = VECS[i].s;  sq_id  = VECS[i].sid;
      sq_mispred = VECS[i].m; st_err = VECS[i].st;
      @(negedge clk);
      chk($sformatf("R1-table vec%0d mc_req", i), int'(mc_req), int'(VECS[i].xr));
      chk($sformatf("R8-table vec%0d mc_precise", i), int'(mc_precise), int'(VECS[i].xp));
    end
    idle_in();
    chk("R9 cnt_precise", int'(cnt_precise), 3);
    chk("R9 cnt_imprecise", int'(cnt_imprecise), 3);

    // R9: store error and wrong-path raise together add 2
    err_vld = 1'b1; err_id = 4'd11; cfg_wp_raise = 1'b1;
    @(negedge clk);
    idle_in();
    cfg_wp_raise = 1'b1; sq_vld = 1'b1; sq_id = 4'd11; sq_mispred = 1'b1; st_err = 1'b1;
    @(negedge clk);
    idle_in();
    chk("R9 double imprecise", int'(cnt_imprecise), 5);
    chk("R9 double req", int'(mc_req), 1);

    // R11 clear
    cnt_clr = 1'b1;
    @(negedge clk);
    idle_in();
    chk("R11 clear precise", int'(cnt_precise), 0);
    chk("R11 clear imprecise", int'(cnt_imprecise), 0);

    // R11 clear wins over increment
    cnt_clr = 1'b1; st_err = 1'b1;
    @(negedge clk);
    idle_in();
    chk("R11 clear beats inc", int'(cnt_imprecise), 0);
    chk("R3 req with clear", int'(mc_req), 1);

    // R10 saturation
    st_err = 1'b1;
    repeat (260) @(negedge clk);
    idle_in();
    chk("R10 saturate", int'(cnt_imprecise), 255);
    chk("R3 req at saturation", int'(mc_req), 1);
    @(negedge clk);
    chk("R10 idle after", int'(mc_req), 0);

    // R12 reset empties table
    err_vld = 1'b1; err_id = 4'd4;
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 cnt after reset", int'(cnt_imprecise), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ret_vld = 1'b1; ret_id = 4'd4;
    @(negedge clk);
    idle_in();
    chk("R12 table empty", int'(mc_req), 0);
    chk("R2 no precise count", int'(cnt_precise), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule